// File: doc/BRIEF.md
# Serially Programmed Bidirectional Trigger Crossbar

This block connects seven local trigger signals (the A side) with seven shared trigger lines (the B side). Every B line can take its value from any one A signal, and every A signal can take its value from any one B line, so triggers can be exported, imported or looped between the two sides. The routing is purely combinational from inputs to outputs. Only the selection is held in registers.

The host programs the routing one bit at a time. Each bit write shifts one bit into a 56-bit staging register. A separate commit strobe then copies the staged pattern into the active control register in a single cycle. Staging a new pattern therefore never disturbs the routing in force until the commit. Every destination pin owns a 4-bit field: an enable bit and a source index. Each output comes with an output-enable, which the pad logic outside this block uses to steer a tri-state driver.

Top module: `trig_xbar`

## Requirements
- R1: While reset is asserted, and after it, the staging register and the control register are all zeros, so every a_oe and b_oe bit is 0 and every a_out and b_out bit is 0.
- R2: At each rising clock edge with shift_we high, the staging register moves up one place and shift_din enters bit 0. After 56 such writes, the first bit written sits at bit 55.
- R3: At a rising edge with load_stb high, the control register takes the staging register's value from before that edge. If shift_we is high on the same edge, the shift does not reach the control register until a later commit.
- R4: The field of B line k occupies control bits [28+4k+3 : 28+4k], and the field of A signal k occupies bits [4k+3 : 4k]. Bit 3 of a field is the enable, and bits 2:0 are the source index.
- R5: a_oe and b_oe change only at a commit edge. Shifting without a commit leaves every output unchanged.
- R6: A B line whose field has enable 1 and index i in 0..6 drives b_oe=1 and b_out equal to a_in[i], combinationally, in the same cycle the input changes.
- R7: An A signal whose field has enable 1 and index i in 0..6 drives a_oe=1 and a_out equal to b_in[i], combinationally.
- R8: A destination whose enable is 0 drives oe=0 and out=0, whatever its index and inputs.
- R9: A destination with enable 1 and index 7 drives oe=1 and out=0.
- R10: One source may feed several destinations at once. A path from a to b and a path from b to a may both be active, because no output depends on another output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_we | input | 1 | Shift one bit into the staging register |
| shift_din | input | 1 | Bit to shift in |
| load_stb | input | 1 | Commit the staged pattern into the control register |
| a_in | input | 7 | Local trigger inputs, sources for B lines |
| a_out | output | 7 | Local trigger outputs, each fed from a B line |
| a_oe | output | 7 | Output enable for each a_out |
| b_in | input | 7 | Shared line inputs, sources for A signals |
| b_out | output | 7 | Shared line outputs, each fed from an A signal |
| b_oe | output | 7 | Output enable for each b_out |

## Verification
The assertions assume that shift_we, shift_din and load_stb are synchronous to clk and settle before each rising edge. They also assume that a_in and b_in carry known values and that nothing outside the block feeds an output back to an input. The bench changes every input only at falling edges, and it checks outputs one time step after a falling edge. The bench drives the two sides from separate stimulus registers and never forms an external loop. This keeps the combinational paths free of races, even with routes in both directions active.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int unsigned XB_DEF_PINS = 7;

    // width of a source index able to name every pin plus one "none" code
    function automatic int unsigned xb_sel_width(input int unsigned pins);
        return $clog2(pins + 1);
    endfunction

    // width of the full routing pattern for both sides
    function automatic int unsigned xb_cfg_width(input int unsigned pins);
        return 2 * pins * (xb_sel_width(pins) + 1);
    endfunction

endpackage

// File: rtl/xbar_shift.sv
module xbar_shift #(
    parameter int unsigned CFG_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             din,
    output logic [CFG_W-1:0] pattern
);

    typedef struct packed {
        logic [CFG_W-1:0] sr;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.sr = {st_q.sr[CFG_W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pattern = st_q.sr;

endmodule

// File: rtl/xbar_ctrl.sv
module xbar_ctrl #(
    parameter int unsigned CFG_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] staged,
    output logic [CFG_W-1:0] active
);

    typedef struct packed {
        logic [CFG_W-1:0] ctrl;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ctrl = staged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.ctrl;

endmodule

// File: rtl/xbar_side.sv
module xbar_side #(
    parameter int unsigned N_PINS  = 7,
    parameter int unsigned SEL_W   = 3,
    localparam int unsigned FIELD_W = SEL_W + 1,
    localparam int unsigned HALF_W  = N_PINS * FIELD_W
) (
    input  logic [HALF_W-1:0] fields,
    input  logic [N_PINS-1:0] src,
    output logic [N_PINS-1:0] dst_out,
    output logic [N_PINS-1:0] dst_oe
);

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] idx;
    } field_t;

    for (genvar k = 0; k < N_PINS; k++) begin : g_dst
        field_t f;
        logic   pick;

        assign f = field_t'(fields[k*FIELD_W +: FIELD_W]);

        always_comb begin
            pick = 1'b0;
            for (int j = 0; j < N_PINS; j++) begin
                if (f.idx == SEL_W'(j)) begin
                    pick = src[j];
                end
            end
        end

        assign dst_oe[k]  = f.en;
        assign dst_out[k] = f.en & pick;
    end

endmodule

// File: rtl/trig_xbar.sv
module trig_xbar
    import xbar_pkg::*;
#(
    parameter int unsigned N_PINS = XB_DEF_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_we,
    input  logic              shift_din,
    input  logic              load_stb,
    input  logic [N_PINS-1:0] a_in,
    output logic [N_PINS-1:0] a_out,
    output logic [N_PINS-1:0] a_oe,
    input  logic [N_PINS-1:0] b_in,
    output logic [N_PINS-1:0] b_out,
    output logic [N_PINS-1:0] b_oe
);

    localparam int unsigned SEL_W  = xb_sel_width(N_PINS);
    localparam int unsigned HALF_W = N_PINS * (SEL_W + 1);
    localparam int unsigned CFG_W  = xb_cfg_width(N_PINS);

    logic [CFG_W-1:0] shift_pat;
    logic [CFG_W-1:0] ctrl_pat;

    xbar_shift #(.CFG_W(CFG_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (shift_we),
        .din     (shift_din),
        .pattern (shift_pat)
    );

    xbar_ctrl #(.CFG_W(CFG_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_stb),
        .staged (shift_pat),
        .active (ctrl_pat)
    );

    // upper half: shared-line destinations fed from local sources
    xbar_side #(.N_PINS(N_PINS), .SEL_W(SEL_W)) u_to_b (
        .fields  (ctrl_pat[CFG_W-1:HALF_W]),
        .src     (a_in),
        .dst_out (b_out),
        .dst_oe  (b_oe)
    );

    // lower half: local destinations fed from shared lines
    xbar_side #(.N_PINS(N_PINS), .SEL_W(SEL_W)) u_to_a (
        .fields  (ctrl_pat[HALF_W-1:0]),
        .src     (b_in),
        .dst_out (a_out),
        .dst_oe  (a_oe)
    );

endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
    parameter int unsigned N_PINS = 7,
    parameter int unsigned SEL_W  = 3,
    localparam int unsigned FIELD_W = SEL_W + 1,
    localparam int unsigned HALF_W  = N_PINS * FIELD_W,
    localparam int unsigned CFG_W   = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_we,
    input logic              shift_din,
    input logic              load_stb,
    input logic [CFG_W-1:0]  sr,
    input logic [N_PINS-1:0] a_out,
    input logic [N_PINS-1:0] a_oe,
    input logic [N_PINS-1:0] b_out,
    input logic [N_PINS-1:0] b_oe
);

    logic [N_PINS-1:0] staged_en_a;
    logic [N_PINS-1:0] staged_en_b;

    always_comb begin
        for (int k = 0; k < N_PINS; k++) begin
            staged_en_a[k] = sr[k*FIELD_W + FIELD_W - 1];
            staged_en_b[k] = sr[HALF_W + k*FIELD_W + FIELD_W - 1];
        end
    end

    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_we |=> sr == $past({sr[CFG_W-2:0], shift_din}));

    p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_we |=> $stable(sr));

    p_commit_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (a_oe == $past(staged_en_a)) && (b_oe == $past(staged_en_b)));

    p_oe_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable(a_oe) && $stable(b_oe));

    p_idle_low_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_out & ~a_oe) == '0);

    p_idle_low_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_out & ~b_oe) == '0);

endmodule

bind trig_xbar xbar_chk #(.N_PINS(N_PINS), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_we  (shift_we),
    .shift_din (shift_din),
    .load_stb  (load_stb),
    .sr        (shift_pat),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_out     (b_out),
    .b_oe      (b_oe)
);

// File: tb/trig_xbar_tb.sv
module trig_xbar_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    // {pattern[55:0], a_in[6:0], b_in[6:0]}
    localparam logic [69:0] VECS [0:NV-1] = '{
        {56'hEDCBA98_EDCBA98, 7'h55, 7'h2A},
        {56'hEDCBA98_EDCBA98, 7'h0F, 7'h71},
        {56'h89ABCDE_BBBBBBB, 7'h13, 7'h08},
        {56'h89ABCDE_BBBBBBB, 7'h6C, 7'h77},
        {56'hF078C2F_3F9A0E1, 7'h7F, 7'h7F},
        {56'hF078C2F_3F9A0E1, 7'h21, 7'h5A},
        {56'h0123456_6543210, 7'h7F, 7'h7F},
        {56'h8888888_9999999, 7'h01, 7'h02}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_we = 1'b0;
    logic       shift_din = 1'b0;
    logic       load_stb = 1'b0;
    logic [6:0] a_in = '0;
    logic [6:0] b_in = '0;
    logic [6:0] a_out, a_oe, b_out, b_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_xbar u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_we  (shift_we),
        .shift_din (shift_din),
        .load_stb  (load_stb),
        .a_in      (a_in),
        .a_out     (a_out),
        .a_oe      (a_oe),
        .b_in      (b_in),
        .b_out     (b_out),
        .b_oe      (b_oe)
    );

    // reference from the field rules: bit3 enable, bits 2:0 index, 7 = none
    function automatic logic [6:0] ref_oe(input logic [27:0] half);
        logic [6:0] r;
        for (int k = 0; k < 7; k++) r[k] = half[4*k+3];
        return r;
    endfunction

    function automatic logic [6:0] ref_out(input logic [27:0] half, input logic [6:0] src);
        logic [6:0] r;
        for (int k = 0; k < 7; k++) begin
            logic [2:0] ix;
            ix = half[4*k +: 3];
            r[k] = half[4*k+3] && (ix != 3'd7) ? src[ix] : 1'b0;
        end
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [55:0] p);
        check(req, "b_oe",  b_oe,  ref_oe(p[55:28]));
        check(req, "b_out", b_out, ref_out(p[55:28], a_in));
        check(req, "a_oe",  a_oe,  ref_oe(p[27:0]));
        check(req, "a_out", a_out, ref_out(p[27:0], b_in));
    endtask

    task automatic shift_pat(input logic [55:0] p);
        for (int i = 55; i >= 0; i--) begin
            @(negedge clk);
            shift_we  = 1'b1;
            shift_din = p[i];
        end
        @(negedge clk);
        shift_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [55:0] p;
        a_in = 7'h7F;
        b_in = 7'h7F;
        repeat (2) @(negedge clk);
        #1;
        // R1: outputs quiet during reset
        check("R1", "a_oe in reset", a_oe, 7'h00);
        check("R1", "b_oe in reset", b_oe, 7'h00);
        check("R1", "a_out in reset", a_out, 7'h00);
        check("R1", "b_out in reset", b_out, 7'h00);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: staging register cleared, a commit with no shifts keeps all off
        commit();
        #1;
        check_all("R1", 56'h0);

        // table walk: R4 R6 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            shift_pat(VECS[v][69:14]);
            commit();
            a_in = VECS[v][13:7];
            b_in = VECS[v][6:0];
            #1;
            check_all("R4/R6/R7/R8/R9/R10", VECS[v][69:14]);
        end

        // R6 R7: combinational follow without any clock edge
        p = 56'h8888888_9999999;
        a_in = 7'h00;
        b_in = 7'h00;
        #1;
        check("R6", "b_out low src", b_out, 7'h00);
        a_in = 7'h01;
        b_in = 7'h02;
        #1;
        check("R6", "b_out fanout of a_in[0]", b_out, 7'h7F);
        check("R7", "a_out fanout of b_in[1]", a_out, 7'h7F);

        // R5: shifting a new pattern without commit changes nothing
        shift_pat(56'h0000000_0000000);
        #1;
        check_all("R5", p);
        commit();
        #1;
        check_all("R5", 56'h0);

        // R3: commit together with a shift takes the pre-shift pattern
        p = 56'hF078C2F_3F9A0E1;
        a_in = 7'h5A;
        b_in = 7'h33;
        shift_pat(p);
        @(negedge clk);
        shift_we  = 1'b1;
        shift_din = 1'b1;
        load_stb  = 1'b1;
        @(negedge clk);
        shift_we = 1'b0;
        load_stb = 1'b0;
        #1;
        check_all("R3", p);
        commit();
        #1;
        check_all("R3", {p[54:0], 1'b1});

        // R1 R2: reset mid-run, then a partial shift of 4 bits lands in A0
        do_reset();
        #1;
        check_all("R1", 56'h0);
        @(negedge clk); shift_we = 1'b1; shift_din = 1'b1;
        @(negedge clk); shift_din = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); shift_we = 1'b0;
        commit();
        b_in = 7'h01;
        #1;
        check("R2", "a_oe partial", a_oe, 7'h01);
        check("R2", "a_out partial", a_out, 7'h01);
        check("R2", "b_oe partial", b_oe, 7'h00);

        // R2: first bit of 56 ends in bit 55 (B6 enable, index 0)
        do_reset();
        shift_pat(56'h8000000_0000000);
        commit();
        a_in = 7'h01;
        #1;
        check("R2", "b_oe order", b_oe, 7'h40);
        check("R2", "b_out order", b_out, 7'h40);
        check("R2", "a_oe order", a_oe, 7'h00);

        // R9: enabled with index 7 drives oe high, value low
        shift_pat(56'hFFFFFFF_FFFFFFF);
        commit();
        a_in = 7'h7F;
        b_in = 7'h7F;
        #1;
        check("R9", "b_oe none", b_oe, 7'h7F);
        check("R9", "b_out none", b_out, 7'h00);
        check("R9", "a_oe none", a_oe, 7'h7F);
        check("R9", "a_out none", a_out, 7'h00);

        finish_run();
    end

endmodule